// File: doc/BRIEF.md
# Rate-Accumulating Energy Pulse Generator

This block turns a signed 32-bit energy rate into a train of active-low output pulses for a metering front end. Once every accumulation interval a new rate is taken, from either an internally computed value or a value written by a host. On every sample tick (one per multiplexer frame, about 2.5 kHz) the block adds the scaled magnitude of that rate to a phase accumulator. Each time the accumulator holds at least one full unit, a pulse starts and one unit is removed. The remainder is kept, so the phase carries over from one interval to the next. Because each pulse is placed on the tick where the unit is reached, the timing error is at most one tick and averages to zero.

The rate is scaled by a multiplier and by a speed factor chosen with two control bits. When the requested rate is higher than the output can follow, the accumulator saturates instead of wrapping, and the pulses run at their maximum rate. The low time of each pulse is half the period that just ended, but never more than a programmable cap. A 32-bit counter counts the pulses. An error flag reports an interval in which the selected source gave no fresh value.

Top module: `energy_pulse_gen`

## Requirements
- R1: While reset is asserted and until the first pulse, `pulse_n` equals `idle_strap`. After reset, `pulse_cnt` is 0 and `rate_err` is 0.
- R2: Each tick adds inc = |rate| × `rate_mult` × K to the accumulator. K depends on the speed bits {`spd_slow`,`spd_fast`}: 00 gives 192, 01 gives 3072, 10 gives 3 and 11 gives 48, which is 32 times the speed factors 6, 96, 0.09375 and 1.5. With unit U = 2^ONE_LOG2, and while no saturation occurs, the final pulse count equals floor(sum of inc / U).
- R3: A negative rate (two's complement) gives the same pulses as its magnitude.
- R4: The rate in use changes only on a cycle where `ivl_start` is high. The accumulator remainder is kept across that load.
- R5: A new pulse can start only on a tick where the previous pulse has already ended, so the shortest spacing between pulse starts is 2 ticks. The accumulator saturates at 2U−1 and does not roll over.
- R6: No pulse is held low for more than 2·`width_set`+1 ticks, and every pulse is low for at least 1 tick.
- R7: A pulse is low for floor(P/2) ticks, where P is the number of ticks since the previous pulse start, capped by R6 and never below 1.
- R8: A pulse start drives `pulse_n` low on that tick. After the first pulse, the idle level is high.
- R9: When `src_host` is 1, an interval loads the host register, which `host_wr` writes with `host_data`. When `src_host` is 0, the interval loads `rate_int` and host writes have no effect on the output.
- R10: On `ivl_start`, `rate_err` takes the value `err_en` AND NOT(the selected source gave an update since the previous `ivl_start`), and it holds that value until the next `ivl_start`. The update for the internal source is `int_upd`; the update for the host source is `host_wr`.
- R11: `pulse_cnt` increases by exactly 1 at each pulse start and changes at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle sample tick |
| ivl_start | input | 1 | Accumulation-interval start strobe |
| src_host | input | 1 | 1: host register source, 0: internal source |
| rate_int | input | 32 | Internal signed rate |
| int_upd | input | 1 | Internal rate refreshed |
| host_wr | input | 1 | Host register write strobe |
| host_data | input | 32 | Host write data (signed rate) |
| rate_mult | input | MULT_W | Rate multiplier |
| spd_slow | input | 1 | Speed select, upper bit |
| spd_fast | input | 1 | Speed select, lower bit |
| width_set | input | PW_W | Low-width cap setting |
| idle_strap | input | 1 | Output level before the first pulse |
| err_en | input | 1 | Missed-update error enable |
| pulse_n | output | 1 | Active-low pulse output |
| pulse_cnt | output | 32 | Pulses started since reset |
| rate_err | output | 1 | Missed-update error flag |

## Verification
The properties are checked on every clock. They cover the counter, which moves only by one and only with a pulse start. They cover start spacing of at least two ticks, the low-time cap, and that the loaded rate and the error flag change only at an interval strobe. The exact pulse counts for each speed code, the handling of negative rates, the phase carried across an interval, the half-period duty, the saturated count, the source mux and the error cases can only be seen in the bench's scenarios. The bench compares those scenarios with values worked out from the scaling formula.

// File: rtl/pgen_pkg.sv
package pgen_pkg;

  // magnitude of a two's complement rate word
  function automatic logic [31:0] mag32(input logic [31:0] v);
    return v[31] ? (~v + 32'd1) : v;
  endfunction

  // left shift applied to 3*|rate|*mult for each speed code {slow,fast}
  function automatic logic [3:0] speed_shift(input logic [1:0] sp);
    case (sp)
      2'b00:   return 4'd6;
      2'b01:   return 4'd10;
      2'b10:   return 4'd0;
      default: return 4'd4;
    endcase
  endfunction

endpackage

// File: rtl/pgen_src.sv
module pgen_src (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ivl_start,
  input  logic        src_host,
  input  logic [31:0] rate_int,
  input  logic        int_upd,
  input  logic        host_wr,
  input  logic [31:0] host_data,
  input  logic        err_en,
  output logic [31:0] rate_q,
  output logic        rate_err
);
  logic [31:0] host_q;
  logic        fresh_q;
  logic        upd_now;

  assign upd_now = src_host ? host_wr : int_upd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_q   <= '0;
      rate_q   <= '0;
      fresh_q  <= 1'b0;
      rate_err <= 1'b0;
    end else begin
      if (host_wr) host_q <= host_data;
      if (ivl_start) begin
        rate_q   <= src_host ? host_q : rate_int;
        rate_err <= err_en & ~(fresh_q | upd_now);
        fresh_q  <= 1'b0;
      end else if (upd_now) begin
        fresh_q  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pgen_accum.sv
module pgen_accum #(
  parameter int MULT_W   = 16,
  parameter int ONE_LOG2 = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start,
  input  logic [31:0]       rate_q,
  input  logic [MULT_W-1:0] mult,
  input  logic [1:0]        speed,
  output logic              acc_full
);
  import pgen_pkg::*;
  localparam int INC_W = 32 + MULT_W + 2 + 10;
  localparam int ACC_W = ONE_LOG2 + 1;
  localparam logic [INC_W:0] ONE_W = (INC_W+1)'(1) << ONE_LOG2;
  localparam logic [INC_W:0] TOP_W = (ONE_W << 1) - (INC_W+1)'(1);

  logic [INC_W-1:0] prod, inc;
  logic [INC_W:0]   sum;
  logic [ACC_W-1:0] acc_q;

  always_comb begin
    prod = INC_W'(mag32(rate_q)) * INC_W'(mult);
    inc  = ((prod << 1) + prod) << speed_shift(speed);
    sum  = (INC_W+1)'(acc_q) + {1'b0, inc} - (start ? ONE_W : '0);
  end

  assign acc_full = acc_q[ACC_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n)    acc_q <= '0;
    else if (tick) acc_q <= (sum > TOP_W) ? '1 : ACC_W'(sum);
  end
endmodule

// File: rtl/pgen_shaper.sv
module pgen_shaper #(
  parameter int PW_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            start,
  input  logic [PW_W-1:0] width_set,
  input  logic            idle_strap,
  output logic            idle,
  output logic            pulse_n,
  output logic [31:0]     pulse_cnt
);
  localparam int PER_W = PW_W + 2;

  logic [PER_W-1:0] low_q, per_q, len;
  logic             started_q;

  function automatic logic [PER_W-1:0] low_len(input logic [PER_W-1:0] per,
                                               input logic [PW_W-1:0]  pw);
    logic [PER_W-1:0] cap, half;
    cap  = PER_W'({pw, 1'b1});
    half = per >> 1;
    if (half > cap) half = cap;
    if (half == '0) half = PER_W'(1);
    return half;
  endfunction

  assign idle    = (low_q == '0);
  assign len     = low_len(per_q, width_set);
  assign pulse_n = started_q ? idle : idle_strap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_q     <= '0;
      per_q     <= '1;
      started_q <= 1'b0;
      pulse_cnt <= '0;
    end else if (tick) begin
      if (start) begin
        low_q     <= len;
        per_q     <= PER_W'(1);
        started_q <= 1'b1;
        pulse_cnt <= pulse_cnt + 32'd1;
      end else begin
        if (!idle) low_q <= low_q - PER_W'(1);
        if (per_q != '1) per_q <= per_q + PER_W'(1);
      end
    end
  end
endmodule

// File: rtl/energy_pulse_gen.sv
module energy_pulse_gen #(
  parameter int MULT_W   = 16,
  parameter int PW_W     = 8,
  parameter int ONE_LOG2 = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ivl_start,
  input  logic              src_host,
  input  logic [31:0]       rate_int,
  input  logic              int_upd,
  input  logic              host_wr,
  input  logic [31:0]       host_data,
  input  logic [MULT_W-1:0] rate_mult,
  input  logic              spd_slow,
  input  logic              spd_fast,
  input  logic [PW_W-1:0]   width_set,
  input  logic              idle_strap,
  input  logic              err_en,
  output logic              pulse_n,
  output logic [31:0]       pulse_cnt,
  output logic              rate_err
);
  logic [31:0] rate_q;
  logic        acc_full, gen_idle, start_w;

  assign start_w = tick & gen_idle & acc_full;

  pgen_src u_src (
    .clk(clk), .rst_n(rst_n), .ivl_start(ivl_start), .src_host(src_host),
    .rate_int(rate_int), .int_upd(int_upd), .host_wr(host_wr),
    .host_data(host_data), .err_en(err_en), .rate_q(rate_q), .rate_err(rate_err)
  );

  pgen_accum #(.MULT_W(MULT_W), .ONE_LOG2(ONE_LOG2)) u_acc (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start_w), .rate_q(rate_q),
    .mult(rate_mult), .speed({spd_slow, spd_fast}), .acc_full(acc_full)
  );

  pgen_shaper #(.PW_W(PW_W)) u_shp (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start_w),
    .width_set(width_set), .idle_strap(idle_strap), .idle(gen_idle),
    .pulse_n(pulse_n), .pulse_cnt(pulse_cnt)
  );
endmodule

// File: rtl/pgen_checker.sv
module pgen_checker #(
  parameter int PW_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick,
  input logic            ivl_start,
  input logic            start_w,
  input logic [31:0]     rate_q,
  input logic            pulse_n,
  input logic [31:0]     pulse_cnt,
  input logic            rate_err,
  input logic [PW_W-1:0] width_set
);
  logic             prev_start, seen;
  logic [PW_W+1:0]  low_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_start <= 1'b0;
      seen       <= 1'b0;
      low_run    <= '0;
    end else if (tick) begin
      prev_start <= start_w;
      if (start_w) seen <= 1'b1;
      if (seen && !pulse_n) low_run <= low_run + 1'b1;
      else                  low_run <= '0;
    end
  end

  p_cnt_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_cnt != $past(pulse_cnt)) |-> (pulse_cnt == $past(pulse_cnt) + 32'd1) && $past(start_w));

  p_start_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |-> !prev_start);

  p_low_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= (PW_W+2)'({width_set, 1'b1}));

  p_start_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |=> !pulse_n);

  p_rate_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ivl_start) |-> $stable(rate_q));

  p_err_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ivl_start) |-> $stable(rate_err));
endmodule

bind energy_pulse_gen pgen_checker #(.PW_W(PW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .ivl_start(ivl_start),
  .start_w(start_w), .rate_q(rate_q), .pulse_n(pulse_n),
  .pulse_cnt(pulse_cnt), .rate_err(rate_err), .width_set(width_set)
);

// File: tb/energy_pulse_gen_tb.sv
module energy_pulse_gen_tb;
  localparam int NV = 6;
  // unit U = 4096 in this bench; K per speed code: 00->192 01->3072 10->3 11->48
  localparam logic [31:0] V_RATE [NV] = '{32'd16, 32'hFFFF_FFF0, 32'd1, 32'd100, 32'd0, 32'd12345};
  localparam logic [15:0] V_MULT [NV] = '{16'd1, 16'd1, 16'd4, 16'd5, 16'd7, 16'd0};
  localparam logic [1:0]  V_SPD  [NV] = '{2'b11, 2'b11, 2'b00, 2'b10, 2'b01, 2'b11};
  localparam int          V_TICK [NV] = '{32, 32, 20, 30, 20, 20};
  localparam int          V_EXP  [NV] = '{6, 6, 3, 10, 0, 0};

  logic clk = 0, rst_n = 0, tick = 0, ivl_start = 0, src_host = 0, int_upd = 0;
  logic host_wr = 0, spd_slow = 1, spd_fast = 1, idle_strap = 1, err_en = 0;
  logic [31:0] rate_int = 0, host_data = 0;
  logic [15:0] rate_mult = 1;
  logic [7:0]  width_set = 0;
  logic        pulse_n, rate_err;
  logic [31:0] pulse_cnt;

  int n_chk = 0, n_bad = 0, cur_run = 0, nruns = 0;
  int runs [0:63];
  bit done = 0;

  energy_pulse_gen #(.MULT_W(16), .PW_W(8), .ONE_LOG2(12)) u_dut (.*);

  always #4 clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic strap, input logic [7:0] pw);
    @(negedge clk);
    rst_n = 0; idle_strap = strap; width_set = pw; tick = 0; ivl_start = 0;
    int_upd = 0; host_wr = 0; rate_int = 0; host_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_run = 0; nruns = 0;
  endtask

  task automatic do_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
      if (!pulse_n) cur_run++;
      else if (cur_run > 0) begin
        if (nruns < 64) runs[nruns] = cur_run;
        nruns++; cur_run = 0;
      end
      @(negedge clk);
    end
  endtask

  task automatic interval;
    @(negedge clk); ivl_start = 1;
    @(negedge clk); ivl_start = 0;
  endtask

  task automatic strobe_int;
    @(negedge clk); int_upd = 1;
    @(negedge clk); int_upd = 0;
  endtask

  task automatic write_host(input logic [31:0] d);
    @(negedge clk); host_wr = 1; host_data = d;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic flush;
    rate_int = 0;
    if (src_host) write_host(32'd0);
    interval;
    do_ticks(20);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state with both strap levels
    do_reset(1'b0, 8'd0);
    @(negedge clk);
    chk("R1 idle low strap", pulse_n, 0);
    chk("R1 count", pulse_cnt, 0);
    chk("R1 err", rate_err, 0);
    do_reset(1'b1, 8'd0);
    @(negedge clk);
    chk("R1 idle high strap", pulse_n, 1);

    // R2 / R3: vector table
    for (int v = 0; v < NV; v++) begin
      do_reset(1'b1, 8'd0);
      rate_mult = V_MULT[v]; {spd_slow, spd_fast} = V_SPD[v];
      rate_int = V_RATE[v];
      interval;
      do_ticks(V_TICK[v]);
      flush;
      chk($sformatf("R2 R3 vector %0d count", v), pulse_cnt, V_EXP[v]);
    end

    // R8: strap low, after first pulse idle is high
    do_reset(1'b0, 8'd0);
    rate_mult = 1; {spd_slow, spd_fast} = 2'b11; rate_int = 32'd16;
    interval;
    do_ticks(12);
    flush;
    chk("R8 idle high after pulse", pulse_n, 1);

    // R4: rate ignored until interval; phase kept across interval
    do_reset(1'b1, 8'd0);
    rate_int = 32'd16;
    do_ticks(20);
    chk("R4 no load without interval", pulse_cnt, 0);
    interval;
    do_ticks(4);
    chk("R4 below one unit", pulse_cnt, 0);
    interval;
    do_ticks(2);
    flush;
    chk("R4 remainder kept", pulse_cnt, 1);

    // R5: saturation, start every second tick, clamp drains one extra
    do_reset(1'b1, 8'd0);
    rate_mult = 16'hFFFF; {spd_slow, spd_fast} = 2'b01; rate_int = 32'h7FFF_FFFF;
    interval;
    do_ticks(40);
    chk("R5 max rate count", pulse_cnt, 20);
    flush;
    chk("R5 no rollover count", pulse_cnt, 21);
    chk("R6 min width 1", runs[0], 1);

    // R6 / R11: slow pulses capped at 2*2+1 = 5 ticks
    do_reset(1'b1, 8'd2);
    rate_mult = 1; {spd_slow, spd_fast} = 2'b11; rate_int = 32'd2;
    interval;
    do_ticks(120);
    chk("R6 pulses seen", nruns, 2);
    chk("R6 first width", runs[0], 5);
    chk("R6 second width", runs[1], 5);
    chk("R11 count equals pulses", pulse_cnt, nruns);

    // R7: period 7..8 ticks -> low 3..4 (first pulse uses the cap)
    do_reset(1'b1, 8'd2);
    rate_int = 32'd12;
    interval;
    do_ticks(60);
    chk("R7 first width", runs[0], 5);
    for (int k = 1; k < 5; k++)
      chk($sformatf("R7 half period run %0d", k), (runs[k] >= 3 && runs[k] <= 4), 1);

    // R9: host source, and host writes ignored with internal source
    do_reset(1'b1, 8'd0);
    src_host = 1; rate_int = 32'd0;
    write_host(32'd16);
    interval;
    do_ticks(32);
    flush;
    chk("R9 host source", pulse_cnt, 6);
    do_reset(1'b1, 8'd0);
    src_host = 0;
    write_host(32'd16);
    rate_int = 32'd0;
    interval;
    do_ticks(32);
    chk("R9 host ignored", pulse_cnt, 0);

    // R10: missed-update error
    do_reset(1'b1, 8'd0);
    err_en = 1; src_host = 0;
    interval;
    @(negedge clk);
    chk("R10 missed update", rate_err, 1);
    do_ticks(3);
    chk("R10 held", rate_err, 1);
    strobe_int;
    interval;
    @(negedge clk);
    chk("R10 fresh internal", rate_err, 0);
    write_host(32'd5);
    interval;
    @(negedge clk);
    chk("R10 host write not counted", rate_err, 1);
    err_en = 0;
    interval;
    @(negedge clk);
    chk("R10 masked", rate_err, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule